// File: doc/BRIEF.md
# Register-Indirect Load/Store Address Unit

This block sits between a 32-bit processor's register read stage and its data memory port. For each instruction it takes the value of an address register, a signed word offset, the value of a data register and the value of the fixed partial-store source register. From these it forms one registered memory request: a word-aligned address, per-byte write enables and the write data. The address register is first rounded down to a word boundary. The offset counts whole words, so it is scaled to bytes before it is added.

Full-word loads and full-word stores may use any register. Byte and half-word stores always take their data from the fixed source register (register zero on the processor side). They write it in place: the lane that is read from that register is the same lane that is enabled in memory, so no data is shifted. The lane number comes either from a small immediate (static form) or from the low bits of the address register (dynamic form). There are no partial loads. A load always returns the whole word, which is captured on a valid/ready handshake with memory, and a later extraction step picks out any sub-field.

Top module: `ldst_unit`

## Requirements
- R1: After reset, mem_req, mem_we, mem_rready and load_done are 0, mem_be is 0 and issue_ready is 1.
- R2: The request address equals (base_val with its two low bits cleared) plus offset_val × 4, taken modulo 2^32. offset_val is a two's-complement word count, and mem_addr[1:0] is always 0 while mem_req is high.
- R3: The operation encodings are 0 load, 1 full store, 2 byte store with immediate lane, 3 byte store with address lane, 4 half store with immediate lane and 5 half store with address lane. An issue is accepted when issue_valid and issue_ready are both high at a clock edge. A known code then raises mem_req for exactly one cycle, starting on the next cycle. Codes 6 and 7 produce no request.
- R4: A full store drives mem_we=1, mem_be=4'b1111 and mem_wdata=store_val.
- R5: A byte store with immediate lane uses lane L=issue_imm[1:0], where lane 0 is bits 7:0. It drives mem_we=1 and mem_be=1<<L. mem_wdata carries r0_val bits [8L+7:8L] in place and zero in every other lane. base_val[1:0] has no effect on the lane.
- R6: A byte store with address lane uses L=base_val[1:0], with the same enables and data as R5. issue_imm has no effect.
- R7: A half store with immediate lane uses H=issue_imm[0]. It drives mem_be=4'b0011 for H=0 or 4'b1100 for H=1. mem_wdata carries r0_val in the enabled lanes and zero elsewhere. base_val[1:0] has no effect.
- R8: A half store with address lane uses H=base_val[1], with the same enables and data as R7. issue_imm has no effect.
- R9: A load request drives mem_we=0, mem_be=0 and mem_wdata=0. mem_rready is 1 from the request cycle until the read handshake. During that time issue_ready is 0 and any issue is ignored, producing no request.
- R10: When mem_rvalid and mem_rready are both high at a clock edge, the whole mem_rdata word appears on load_data. load_done is 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction present this cycle |
| issue_ready | output | 1 | Unit can accept an instruction |
| issue_op | input | 3 | Operation code (see R3) |
| issue_imm | input | 2 | Static lane selector |
| base_val | input | 32 | Address register value |
| offset_val | input | 32 | Signed word offset register value |
| store_val | input | 32 | Data register value for full stores |
| r0_val | input | 32 | Fixed partial-store source register value |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte write enables |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rready | output | 1 | Unit waits for read data |
| mem_rdata | input | 32 | Read data |
| load_done | output | 1 | Loaded word available (one cycle) |
| load_data | output | 32 | Loaded word |

## Verification
The bench builds the unit with its default 32-bit word and address. That gives four byte lanes and two half-word lanes, so each lane selector has at most four values. This small selector space makes a full cross of all eight operation codes, all four low address bit patterns and all four immediate values affordable. That cross runs against word offsets from −2 to +2 on bases that include the zero and all-ones regions, which also covers wraparound in both directions. Loads in the sweep also try an issue while the read is still outstanding, to confirm it is blocked.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    typedef enum logic [2:0] {
        OP_LOAD     = 3'd0,
        OP_STORE    = 3'd1,
        OP_ST8_IMM  = 3'd2,
        OP_ST8_ADR  = 3'd3,
        OP_ST16_IMM = 3'd4,
        OP_ST16_ADR = 3'd5
    } ldst_op_e;

    typedef struct packed {
        logic known;
        logic store;
        logic full;
        logic byte_st;
        logic half_st;
        logic lane_from_adr;
    } ldst_dec_t;

    function automatic ldst_dec_t ldst_decode(input logic [2:0] code);
        ldst_dec_t d;
        d = '0;
        case (code)
            OP_LOAD:     begin d.known = 1'b1; d.full = 1'b1; end
            OP_STORE:    begin d.known = 1'b1; d.store = 1'b1; d.full = 1'b1; end
            OP_ST8_IMM:  begin d.known = 1'b1; d.store = 1'b1; d.byte_st = 1'b1; end
            OP_ST8_ADR:  begin d.known = 1'b1; d.store = 1'b1; d.byte_st = 1'b1;
                               d.lane_from_adr = 1'b1; end
            OP_ST16_IMM: begin d.known = 1'b1; d.store = 1'b1; d.half_st = 1'b1; end
            OP_ST16_ADR: begin d.known = 1'b1; d.store = 1'b1; d.half_st = 1'b1;
                               d.lane_from_adr = 1'b1; end
            default:     d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ldst_agen.sv
// Effective address: base rounded down to a word, plus a word-scaled offset.
module ldst_agen #(
    parameter int ADDR_W = 32,
    parameter int NBYTES = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offset_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int SH = $clog2(NBYTES);

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] scaled;

    always_comb begin
        aligned = base_i;
        aligned[SH-1:0] = '0;
        scaled = offset_i << SH;
        addr_o = aligned + scaled;
    end
endmodule

// File: rtl/ldst_lane_ctl.sv
// Byte-enable and in-place write data generation for full and partial stores.
module ldst_lane_ctl #(
    parameter int DATA_W = 32
) (
    input  logic                      full_st_i,
    input  logic                      byte_st_i,
    input  logic                      half_st_i,
    input  logic                      lane_from_adr_i,
    input  logic [$clog2(DATA_W/8)-1:0] adr_low_i,
    input  logic [$clog2(DATA_W/8)-1:0] imm_i,
    input  logic [DATA_W-1:0]         store_val_i,
    input  logic [DATA_W-1:0]         r0_val_i,
    output logic [DATA_W/8-1:0]       be_o,
    output logic [DATA_W-1:0]         wdata_o
);
    localparam int NB     = DATA_W / 8;
    localparam int LSEL_W = $clog2(NB);
    localparam int NH     = NB / 2;
    localparam int HSEL_W = (NH > 1) ? $clog2(NH) : 1;

    logic [LSEL_W-1:0] byte_sel;
    logic [HSEL_W-1:0] half_sel;

    always_comb begin
        byte_sel = lane_from_adr_i ? adr_low_i : imm_i;
        half_sel = lane_from_adr_i ? adr_low_i[LSEL_W-1 -: HSEL_W]
                                   : imm_i[HSEL_W-1:0];
    end

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic hit_byte;
        logic hit_half;
        always_comb begin
            hit_byte = byte_st_i && (byte_sel == LSEL_W'(g));
            hit_half = half_st_i && (half_sel == HSEL_W'(g / 2));
            be_o[g]  = full_st_i || hit_byte || hit_half;
            if (full_st_i)
                wdata_o[8*g +: 8] = store_val_i[8*g +: 8];
            else if (hit_byte || hit_half)
                wdata_o[8*g +: 8] = r0_val_i[8*g +: 8];
            else
                wdata_o[8*g +: 8] = 8'h00;
        end
    end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int NB     = DATA_W / 8,
    localparam int LSEL_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    output logic              issue_ready,
    input  logic [2:0]        issue_op,
    input  logic [LSEL_W-1:0] issue_imm,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] offset_val,
    input  logic [DATA_W-1:0] store_val,
    input  logic [DATA_W-1:0] r0_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [NB-1:0]     mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    output logic              mem_rready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              load_done,
    output logic [DATA_W-1:0] load_data
);
    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [NB-1:0]     be;
        logic [DATA_W-1:0] wdata;
        logic              pending;
        logic              done;
        logic [DATA_W-1:0] ldata;
    } unit_state_t;

    unit_state_t st_d, st_q;
    ldst_dec_t   dec;
    logic [ADDR_W-1:0] ea;
    logic [NB-1:0]     lane_be;
    logic [DATA_W-1:0] lane_wdata;
    logic              accept;

    assign dec = ldst_decode(issue_op);

    ldst_agen #(.ADDR_W(ADDR_W), .NBYTES(NB)) u_agen (
        .base_i   (base_val),
        .offset_i (offset_val),
        .addr_o   (ea)
    );

    ldst_lane_ctl #(.DATA_W(DATA_W)) u_lane (
        .full_st_i       (dec.full && dec.store),
        .byte_st_i       (dec.byte_st),
        .half_st_i       (dec.half_st),
        .lane_from_adr_i (dec.lane_from_adr),
        .adr_low_i       (base_val[LSEL_W-1:0]),
        .imm_i           (issue_imm),
        .store_val_i     (store_val),
        .r0_val_i        (r0_val),
        .be_o            (lane_be),
        .wdata_o         (lane_wdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.req  = 1'b0;
        st_d.done = 1'b0;
        accept    = issue_valid && !st_q.pending;
        if (accept && dec.known) begin
            st_d.req     = 1'b1;
            st_d.we      = dec.store;
            st_d.addr    = ea;
            st_d.be      = lane_be;
            st_d.wdata   = lane_wdata;
            st_d.pending = !dec.store;
        end
        if (st_q.pending && mem_rvalid) begin
            st_d.pending = 1'b0;
            st_d.done    = 1'b1;
            st_d.ldata   = mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue_ready = !st_q.pending;
    assign mem_req     = st_q.req;
    assign mem_we      = st_q.we && st_q.req;
    assign mem_addr    = st_q.addr;
    assign mem_be      = st_q.req ? st_q.be : '0;
    assign mem_wdata   = st_q.wdata;
    assign mem_rready  = st_q.pending;
    assign load_done   = st_q.done;
    assign load_data   = st_q.ldata;
endmodule

// File: rtl/ldst_unit_chk.sv
module ldst_unit_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_valid,
    input logic              issue_ready,
    input logic [2:0]        issue_op,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic              mem_rvalid,
    input logic              mem_rready,
    input logic              load_done
);
    localparam int NB = DATA_W / 8;
    localparam int SH = $clog2(NB);

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[SH-1:0] == '0)); // R2
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R3
    AST_REQ_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(issue_valid && issue_ready)); // R3
    AST_BAD_OP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_ready && issue_op > 3'd5) |=> !mem_req); // R3
    AST_STORE_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                                 || $countones(mem_be) == NB)); // R4
    AST_LOAD_NO_BE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (mem_be == '0)); // R9
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rready |-> !issue_ready); // R9
    AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> $past(mem_rvalid && mem_rready)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done); // R10
endmodule

bind ldst_unit ldst_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_valid (issue_valid),
    .issue_ready (issue_ready),
    .issue_op    (issue_op),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_be      (mem_be),
    .mem_rvalid  (mem_rvalid),
    .mem_rready  (mem_rready),
    .load_done   (load_done)
);

// File: tb/tb_ldst_unit.sv
module tb_ldst_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        issue_ready;
    logic [2:0]  issue_op = '0;
    logic [1:0]  issue_imm = '0;
    logic [31:0] base_val = '0, offset_val = '0, store_val = '0, r0_val = '0;
    logic        mem_req, mem_we, mem_rready, load_done;
    logic [31:0] mem_addr, mem_wdata, load_data;
    logic [3:0]  mem_be;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_unit dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .issue_op(issue_op), .issue_imm(issue_imm), .base_val(base_val),
        .offset_val(offset_val), .store_val(store_val), .r0_val(r0_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rready(mem_rready),
        .mem_rdata(mem_rdata), .load_done(load_done), .load_data(load_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input int op, input logic [31:0] b, input logic [1:0] imm);
        case (op)
            1: return 4'hF;
            2: return 4'b0001 << imm;
            3: return 4'b0001 << b[1:0];
            4: return imm[0] ? 4'b1100 : 4'b0011;
            5: return b[1] ? 4'b1100 : 4'b0011;
            default: return 4'h0;
        endcase
    endfunction

    function automatic string tag(input int op);
        case (op)
            0: return "R9";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R3";
        endcase
    endfunction

    task automatic run_op(input int op, input logic [31:0] b, input logic [31:0] off,
                          input logic [1:0] imm, input logic [31:0] sv, input logic [31:0] rv);
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] rd;
        be = exp_be(op, b, imm);
        wd = '0;
        for (int i = 0; i < 4; i++)
            if (be[i]) wd[8*i +: 8] = (op == 1) ? sv[8*i +: 8] : rv[8*i +: 8];
        @(negedge clk);
        issue_valid = 1'b1; issue_op = 3'(op); issue_imm = imm;
        base_val = b; offset_val = off; store_val = sv; r0_val = rv;
        @(negedge clk);
        issue_valid = 1'b0;
        if (op > 5) begin
            chk("R3 no request for unknown code", {31'b0, mem_req}, 32'd0);
            return;
        end
        chk("R3 request raised", {31'b0, mem_req}, 32'd1);
        chk("R2 address", mem_addr, (b & 32'hFFFF_FFFC) + (off << 2));
        chk({tag(op), " write enable"}, {31'b0, mem_we}, (op == 0) ? 32'd0 : 32'd1);
        chk({tag(op), " byte enables"}, {28'b0, mem_be}, {28'b0, be});
        chk({tag(op), " write data"}, mem_wdata, wd);
        if (op == 0)
            chk("R9 rready with request", {31'b0, mem_rready}, 32'd1);
        @(negedge clk);
        chk("R3 request one cycle", {31'b0, mem_req}, 32'd0);
        if (op == 0) begin
            chk("R9 issue blocked", {31'b0, issue_ready}, 32'd0);
            issue_valid = 1'b1; issue_op = 3'd1;
            @(negedge clk);
            issue_valid = 1'b0;
            chk("R9 issue ignored while busy", {31'b0, mem_req}, 32'd0);
            rd = sv ^ 32'hA5C3_0F96;
            mem_rvalid = 1'b1; mem_rdata = rd;
            @(negedge clk);
            mem_rvalid = 1'b0;
            chk("R10 load_done", {31'b0, load_done}, 32'd1);
            chk("R10 load_data", load_data, rd);
            @(negedge clk);
            chk("R10 load_done one cycle", {31'b0, load_done}, 32'd0);
            chk("R9 rready dropped", {31'b0, mem_rready}, 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mem_req reset", {31'b0, mem_req}, 32'd0);
        chk("R1 mem_we reset", {31'b0, mem_we}, 32'd0);
        chk("R1 mem_rready reset", {31'b0, mem_rready}, 32'd0);
        chk("R1 load_done reset", {31'b0, load_done}, 32'd0);
        chk("R1 mem_be reset", {28'b0, mem_be}, 32'd0);
        chk("R1 issue_ready reset", {31'b0, issue_ready}, 32'd1);
        rst_n = 1'b1;
        for (int op = 0; op < 8; op++)
            for (int bi = 0; bi < 3; bi++)
                for (int lo = 0; lo < 4; lo++)
                    for (int imm = 0; imm < 4; imm++)
                        for (int oi = 0; oi < 5; oi++) begin
                            logic [31:0] b;
                            logic [31:0] sv;
                            b = (bi == 0) ? 32'h0 : (bi == 1) ? 32'h1234_5670 : 32'hFFFF_FFFC;
                            b[1:0] = 2'(lo);
                            sv = 32'h0102_0304 * (op + 1) + 32'h1111_0000 * lo + 32'h0F0F * (imm + oi);
                            run_op(op, b, 32'(oi - 2), 2'(imm), sv, ~sv + 32'h3579_BDF1);
                        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule